// File: doc/BRIEF.md
# Masked Data Watchpoint Unit

This unit holds a small set of data watchpoints and checks every memory access against them before the access is carried out. Each watchpoint has an address register and a control register. The control register carries two enables, one for loads and one for stores, and a six-bit compare field. The compare field selects which low address bits take part in the comparison. A probed access whose address falls in the watched region, and whose direction is enabled, raises `hit` in the same cycle. `hit_idx` then names the watchpoint that matched.

The region is always a naturally aligned block whose size is a power of two. Address bits above the compare field are always compared. A compare field with gaps in it is reduced to its run of ones counted from the top bit, so the region grows to the next valid aligned size instead of becoming sparse. The unit also holds an instruction-breakpoint enable register. It keeps only as many bits as there are implemented instruction breakpoints, and its value is driven out on `ibrk_en`.

Software-side writes arrive on a single register write port. A write changes the comparison from the next clock cycle onward.

Top module: `dbg_watch`

## Requirements
- R1: After reset, every control register reads as disabled, so no access hits. `ibrk_en` is zero.
- R2: When the compare field is 6'h3F, only the exact address in the watchpoint's address register hits.
- R3: When the compare field is a contiguous run of ones from bit 5 down to bit k, bits below k are ignored. The region is the aligned 2^k block that contains the stored address, whatever the stored low bits are.
- R4: When the compare field is not contiguous from bit 5, only its leading ones are kept. Example: 6'h2F acts as 6'h20 and ignores address bits 4..0.
- R5: A store hits only when control bit 31 (store enable) is set.
- R6: A load hits only when control bit 30 (load enable) is set. When bits 30 and 31 are both clear, the watchpoint never hits.
- R7: When several watchpoints match, `hit_idx` gives the lowest index.
- R8: `hit` and `hit_idx` are combinational from the probe inputs. With `acc_valid` low, `hit` is 0.
- R9: A register write changes the match result only after the clock edge that takes the write in.
- R10: Writing the instruction-breakpoint enable register (`wr_sel`=2) keeps only the low NUM_IBRK bits. The upper bits of `ibrk_en` read as zero.
- R11: Address bits above the compare field are always compared.

Register select encoding: `wr_sel`=0 writes the address of watchpoint `wr_idx`, 1 writes its control, and 2 writes the instruction-breakpoint enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 address, 1 control, 2 instruction-breakpoint enable |
| wr_idx | input | IDX_W | Watchpoint index for address and control writes |
| wr_data | input | AW | Write data |
| acc_valid | input | 1 | An access is being probed |
| acc_addr | input | AW | Access address |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| hit | output | 1 | The access matches an enabled watchpoint |
| hit_idx | output | IDX_W | Lowest matching watchpoint index, 0 when there is no hit |
| ibrk_en | output | AW | Instruction-breakpoint enable value, zero-extended |

## Verification
The comparison is probed with addresses just inside and just outside each region. This separates an exact match, an aligned 8-byte region whose stored address has nonzero low bits, and a gapped compare field. For the gapped field, one address hits only if the field has been truncated, so it tells truncation apart from using the raw field as the mask. Flipping only a high address bit shows that the upper bits are always compared. Loads and stores are tried under each enable combination to confirm the two directions are qualified separately. Two watchpoints set to the same address check the priority, and a probe held steady across a write checks which cycle the write takes effect in.

// File: rtl/dbg_watch.sv
module dbg_watch #(
  parameter int AW       = 32,
  parameter int NUM_WP   = 2,
  parameter int NUM_IBRK = 2,
  parameter int FIELD_W  = 6,
  parameter int LD_BIT   = 30,
  parameter int ST_BIT   = 31,
  localparam int IDX_W   = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [AW-1:0]    wr_data,
  input  logic             acc_valid,
  input  logic [AW-1:0]    acc_addr,
  input  logic             acc_store,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [AW-1:0]    ibrk_en
);

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_IBRK = 2'd2;

  logic [AW-1:0]      wp_addr  [NUM_WP];
  logic [FIELD_W-1:0] wp_field [NUM_WP];
  logic               wp_ld    [NUM_WP];
  logic               wp_st    [NUM_WP];
  logic [NUM_IBRK-1:0] ien_q;
  logic [NUM_WP-1:0]  cand;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WP; i++) begin
        wp_addr[i]  <= '0;
        wp_field[i] <= '0;
        wp_ld[i]    <= 1'b0;
        wp_st[i]    <= 1'b0;
      end
      ien_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_WP; i++) begin
        if (wr_idx == IDX_W'(i)) begin
          if (wr_sel == SEL_ADDR) wp_addr[i] <= wr_data;
          if (wr_sel == SEL_CTRL) begin
            wp_field[i] <= wr_data[FIELD_W-1:0];
            wp_ld[i]    <= wr_data[LD_BIT];
            wp_st[i]    <= wr_data[ST_BIT];
          end
        end
      end
      if (wr_sel == SEL_IBRK) ien_q <= wr_data[NUM_IBRK-1:0];
    end
  end

  for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
    logic [FIELD_W-1:0] kept;
    logic [AW-1:0]      mask;
    for (genvar b = 0; b < FIELD_W; b++) begin : g_bit
      assign kept[b] = &wp_field[g][FIELD_W-1:b];
    end
    assign mask    = {{(AW-FIELD_W){1'b1}}, kept};
    assign cand[g] = acc_valid && (acc_store ? wp_st[g] : wp_ld[g]) &&
                     (((acc_addr ^ wp_addr[g]) & mask) == '0);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NUM_WP - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign ibrk_en = AW'(ien_q);

  p_idle_no_hit_r8: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |-> !hit);

  p_dir_enabled_r5: assert property (@(posedge clk) disable iff (rst)
    hit |-> (acc_store ? wp_st[hit_idx] : wp_ld[hit_idx]));

  p_upper_match_r11: assert property (@(posedge clk) disable iff (rst)
    hit |-> (acc_addr[AW-1:FIELD_W] == wp_addr[hit_idx][AW-1:FIELD_W]));

  p_ien_trunc_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_IBRK) |=>
      (ibrk_en == AW'($past(wr_data[NUM_IBRK-1:0]))));

  p_lowest_idx_r7: assert property (@(posedge clk) disable iff (rst)
    (hit && hit_idx != '0) |-> !cand[0]);

endmodule

// File: tb/dbg_watch_tb.sv
module dbg_watch_tb;
  localparam int CLK_P = 10;
  localparam int AW = 32;
  localparam int IDX_W = 1;

  logic clk = 0, rst = 1;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [IDX_W-1:0] wr_idx = 0;
  logic [AW-1:0] wr_data = 0;
  logic acc_valid = 0, acc_store = 0;
  logic [AW-1:0] acc_addr = 0;
  logic hit;
  logic [IDX_W-1:0] hit_idx;
  logic [AW-1:0] ibrk_en;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  dbg_watch u_dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_idx(wr_idx), .wr_data(wr_data), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_store(acc_store), .hit(hit),
    .hit_idx(hit_idx), .ibrk_en(ibrk_en));

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] sel, logic [IDX_W-1:0] idx, logic [AW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic probe(string req, logic [AW-1:0] a, logic st, logic eh, logic [IDX_W-1:0] ei);
    acc_valid = 1; acc_addr = a; acc_store = st;
    #1;
    check({req, " hit"}, AW'(hit), AW'(eh));
    if (eh) check({req, " idx"}, AW'(hit_idx), AW'(ei));
  endtask

  task automatic t_reset;
    probe("R1 load", 32'h0, 0, 0, 0);
    probe("R1 store", 32'h0, 1, 0, 0);
    check("R1 ibrk_en", ibrk_en, 0);
  endtask

  task automatic t_exact;
    wreg(0, 0, 32'h1000_0040);
    wreg(1, 0, 32'hC000_003F);
    probe("R2 same", 32'h1000_0040, 0, 1, 0);
    probe("R2 plus1", 32'h1000_0041, 0, 0, 0);
    probe("R11 high bit", 32'h9000_0040, 0, 0, 0);
  endtask

  task automatic t_region;
    wreg(0, 0, 32'h1000_0045);
    wreg(1, 0, 32'hC000_0038);
    probe("R3 base", 32'h1000_0040, 1, 1, 0);
    probe("R3 top", 32'h1000_0047, 1, 1, 0);
    probe("R3 beyond", 32'h1000_0048, 1, 0, 0);
    probe("R3 below", 32'h1000_003F, 1, 0, 0);
  endtask

  task automatic t_trunc;
    wreg(0, 0, 32'h2000_0000);
    wreg(1, 0, 32'hC000_002F);
    probe("R4 low nibble zero", 32'h2000_0010, 0, 1, 0);
    probe("R4 top of 32", 32'h2000_001F, 0, 1, 0);
    probe("R4 next block", 32'h2000_0020, 0, 0, 0);
  endtask

  task automatic t_qual;
    wreg(0, 0, 32'h3000_0100);
    wreg(1, 0, 32'h8000_003F);
    probe("R5 store en store", 32'h3000_0100, 1, 1, 0);
    probe("R5 store en load", 32'h3000_0100, 0, 0, 0);
    wreg(1, 0, 32'h4000_003F);
    probe("R6 load en load", 32'h3000_0100, 0, 1, 0);
    probe("R6 load en store", 32'h3000_0100, 1, 0, 0);
    wreg(1, 0, 32'h0000_003F);
    probe("R6 off load", 32'h3000_0100, 0, 0, 0);
    probe("R6 off store", 32'h3000_0100, 1, 0, 0);
  endtask

  task automatic t_prio;
    wreg(0, 0, 32'h4000_0000);
    wreg(1, 0, 32'hC000_003F);
    wreg(0, 1, 32'h4000_0000);
    wreg(1, 1, 32'hC000_003F);
    probe("R7 both", 32'h4000_0000, 0, 1, 0);
    wreg(1, 0, 32'h0000_003F);
    probe("R7 second only", 32'h4000_0000, 0, 1, 1);
  endtask

  task automatic t_idle;
    acc_valid = 0; acc_addr = 32'h4000_0000; acc_store = 0;
    #1;
    check("R8 idle", AW'(hit), 0);
  endtask

  task automatic t_timing;
    @(negedge clk);
    acc_valid = 1; acc_addr = 32'h4000_0000; acc_store = 1;
    wr_en = 1; wr_sel = 1; wr_idx = 1; wr_data = 32'h0000_003F;
    #1;
    check("R9 before edge", AW'(hit), 1);
    @(posedge clk);
    #1;
    wr_en = 0;
    check("R9 after edge", AW'(hit), 0);
  endtask

  task automatic t_ien;
    wreg(2, 0, 32'hFFFF_FFFF);
    #1;
    check("R10 all ones", ibrk_en, 32'h3);
    wreg(2, 0, 32'hFFFF_FFF2);
    #1;
    check("R10 pattern", ibrk_en, 32'h2);
  endtask

  initial begin
    #(CLK_P * 5000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_exact();
    t_region();
    t_trunc();
    t_qual();
    t_prio();
    t_idle();
    t_timing();
    t_ien();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule